// File: doc/BRIEF.md
# Split-Transaction Bus Outstanding-Transaction Table

Each node on a split-transaction snooping bus keeps one copy of this table. Requests and responses travel on separate buses, and a response names its transaction only by tag. The table watches every request that other nodes place on the request bus and records it under its tag, with the command and the line address. It also decides, in the same cycle, what happens to a request from its own node: the request issues with a tag taken from the node's own tag range, it joins a read that is already in flight, it is held back because another transaction to the same line is outstanding, or it is refused (NACK) because the node has no free tag left.

Read and read-exclusive transactions stay in the table until the final beat of their response. A response may name any outstanding tag in any order. Writebacks and invalidates have no response phase, so their entries live for a single cycle after the request. The response side reports a tag that names no transaction waiting for a response, a response that a joined local load is waiting for, and a response that belongs to this node's own requests.

Command encoding on both request paths: 2'b00 read, 2'b01 read-exclusive, 2'b10 writeback, 2'b11 invalidate. The node's tags are `NODE_ID*LOCAL_MAX` up to `NODE_ID*LOCAL_MAX + LOCAL_MAX - 1`.

Top module: `sbus_txn_table`

## Requirements
- R1: After reset the table holds no entries, every decision and response output is 0 while nothing is presented, and the first local request issues with tag `NODE_ID*LOCAL_MAX`.
- R2: An issued local request is given the lowest-numbered free tag of the node's range, reported on `lreq_tag` in the same cycle, and that tag is in use from the next cycle on.
- R3: The node never holds more than `LOCAL_MAX` tags. A local request with no line conflict while all of them are in use gets `lreq_nack` and records nothing.
- R4: A local read-exclusive (01), writeback (10) or invalidate (11) is blocked (`lreq_block`) when any table entry holds the same line, or when a remote request to that line is on the request bus in the same cycle.
- R5: A local read (00) to a line with an outstanding read and no other kind of transaction joins that read: `lreq_snarf` is 1, `lreq_tag` gives the lowest such tag (a table entry before a same-cycle remote read), no tag is used, and the response to that tag raises `rsp_snarf`.
- R6: A local read is blocked when the line has an outstanding read-exclusive, writeback or invalidate, in the table or on the request bus in the same cycle.
- R7: A read or read-exclusive entry stays valid through non-final response beats and is freed in the cycle after the beat with `rsp_last` = 1; a local tag freed this way can issue again from that cycle on.
- R8: A writeback or invalidate entry is valid only in the one cycle after its request, and blocks conflicting local requests during that cycle.
- R9: Responses are accepted for any outstanding read or read-exclusive tag in any order.
- R10: A response whose tag holds no valid read or read-exclusive entry raises `rsp_err` in the same cycle and changes no entry.
- R11: `rsp_local` is 1 for an accepted response whose tag is in the node's range, and 0 for a response to another node.
- R12: At most one of `lreq_issue`, `lreq_snarf`, `lreq_block`, `lreq_nack` is 1, all are 0 when `lreq_valid` is 0, and `lreq_tag` is 0 unless issue or join.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lreq_valid | input | 1 | Local request presented this cycle |
| lreq_cmd | input | 2 | Local command (00 rd, 01 rdx, 10 wb, 11 inv) |
| lreq_addr | input | ADDR_W | Local line address |
| lreq_issue | output | 1 | Local request issues with `lreq_tag` |
| lreq_snarf | output | 1 | Local read joins the in-flight read `lreq_tag` |
| lreq_block | output | 1 | Local request held because of a line conflict |
| lreq_nack | output | 1 | Local request refused, no free tag |
| lreq_tag | output | TAG_W | Tag given or joined |
| breq_valid | input | 1 | Remote request on the request bus |
| breq_cmd | input | 2 | Remote command |
| breq_addr | input | ADDR_W | Remote line address |
| breq_tag | input | TAG_W | Remote tag |
| rsp_valid | input | 1 | Response beat on the response bus |
| rsp_tag | input | TAG_W | Response tag |
| rsp_last | input | 1 | Final beat of the response |
| rsp_err | output | 1 | Response tag has no waiting transaction |
| rsp_snarf | output | 1 | A joined local load waits on this response |
| rsp_local | output | 1 | Response belongs to this node |

## Verification
On every cycle the assertions check that the four decisions exclude each other, that the node's tag count never passes its limit and a NACK only comes with the range full, that an issued tag was free and in range and that nothing issues over a line hit, that a final beat frees its entry, that writeback and invalidate entries vanish after one cycle, and that a stray response tag is flagged. Which decision a given pair of commands produces, which tag is chosen or joined, out-of-order completion and the join flag on the later response are shown only by the bench's sweep over every remote/local command pair, in successive and in the same cycle, against its own model of the table.

// File: rtl/sbus_tt_pkg.sv
package sbus_tt_pkg;

  typedef enum logic [1:0] {
    CMD_RD  = 2'b00,
    CMD_RDX = 2'b01,
    CMD_WB  = 2'b10,
    CMD_INV = 2'b11
  } sbus_cmd_e;

  // Transactions that wait for a data response on the response bus.
  function automatic logic carries_response(input sbus_cmd_e c);
    return (c == CMD_RD) || (c == CMD_RDX);
  endfunction

  // First tag owned by a node.
  function automatic int unsigned node_tag_base(input int unsigned node, input int unsigned per_node);
    return node * per_node;
  endfunction

  // True when a tag lies in a node's own range.
  function automatic logic tag_is_local(input int unsigned tag, input int unsigned base,
                                        input int unsigned count);
    return (tag >= base) && (tag < base + count);
  endfunction

endpackage

// File: rtl/sbus_tt_entries.sv
module sbus_tt_entries
  import sbus_tt_pkg::*;
#(
  parameter int unsigned TAG_W    = 7,
  parameter int unsigned ADDR_W   = 26,
  parameter int unsigned NUM_TAGS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                l_alloc,
  input  logic [TAG_W-1:0]    l_tag,
  input  sbus_cmd_e           l_cmd,
  input  logic [ADDR_W-1:0]   l_addr,
  input  logic                r_alloc,
  input  logic [TAG_W-1:0]    r_tag,
  input  sbus_cmd_e           r_cmd,
  input  logic [ADDR_W-1:0]   r_addr,
  input  logic                rsp_valid,
  input  logic [TAG_W-1:0]    rsp_tag,
  input  logic                rsp_last,
  input  logic                join_set,
  input  logic [TAG_W-1:0]    join_tag,
  input  logic [ADDR_W-1:0]   look_addr,
  output logic [NUM_TAGS-1:0] valid_vec,
  output logic [NUM_TAGS-1:0] expect_vec,
  output logic [NUM_TAGS-1:0] joined_vec,
  output logic [NUM_TAGS-1:0] rd_hit_vec,
  output logic [NUM_TAGS-1:0] other_hit_vec
);

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_ent
    logic              v_q;
    logic              j_q;
    sbus_cmd_e         c_q;
    logic [ADDR_W-1:0] a_q;
    logic              own_alloc;
    logic              bus_alloc;
    logic              join_hit;
    logic              rsp_done;
    logic              one_shot_done;
    logic              line_eq;

    assign own_alloc     = l_alloc && (l_tag == TAG_W'(g));
    assign bus_alloc     = r_alloc && (r_tag == TAG_W'(g));
    assign join_hit      = join_set && (join_tag == TAG_W'(g));
    assign rsp_done      = rsp_valid && rsp_last && (rsp_tag == TAG_W'(g)) &&
                           v_q && carries_response(c_q);
    assign one_shot_done = v_q && !carries_response(c_q);
    assign line_eq       = v_q && (a_q == look_addr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        j_q <= 1'b0;
        c_q <= CMD_RD;
        a_q <= '0;
      end else if (own_alloc) begin
        v_q <= 1'b1;
        j_q <= join_hit;
        c_q <= l_cmd;
        a_q <= l_addr;
      end else if (bus_alloc) begin
        v_q <= 1'b1;
        j_q <= join_hit;
        c_q <= r_cmd;
        a_q <= r_addr;
      end else if (rsp_done || one_shot_done) begin
        v_q <= 1'b0;
        j_q <= 1'b0;
      end else if (join_hit) begin
        j_q <= 1'b1;
      end
    end

    assign valid_vec[g]     = v_q;
    assign expect_vec[g]    = v_q && carries_response(c_q);
    assign joined_vec[g]    = j_q;
    assign rd_hit_vec[g]    = line_eq && (c_q == CMD_RD);
    assign other_hit_vec[g] = line_eq && (c_q != CMD_RD);
  end

endmodule

// File: rtl/sbus_tt_tag_pool.sv
module sbus_tt_tag_pool
  import sbus_tt_pkg::*;
#(
  parameter int unsigned TAG_W      = 7,
  parameter int unsigned NUM_TAGS   = 128,
  parameter int unsigned LOCAL_BASE = 0,
  parameter int unsigned LOCAL_MAX  = 7,
  parameter int unsigned CNT_W      = 3
) (
  input  logic [NUM_TAGS-1:0] valid_vec,
  output logic                free_any,
  output logic [TAG_W-1:0]    free_tag,
  output logic [CNT_W-1:0]    busy_cnt
);

  always_comb begin
    free_any = 1'b0;
    free_tag = '0;
    busy_cnt = '0;
    for (int i = int'(LOCAL_MAX) - 1; i >= 0; i--) begin
      if (!valid_vec[int'(LOCAL_BASE) + i]) begin
        free_any = 1'b1;
        free_tag = TAG_W'(int'(LOCAL_BASE) + i);
      end else begin
        busy_cnt = busy_cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sbus_tt_issue_ctl.sv
module sbus_tt_issue_ctl
  import sbus_tt_pkg::*;
#(
  parameter int unsigned TAG_W    = 7,
  parameter int unsigned ADDR_W   = 26,
  parameter int unsigned NUM_TAGS = 128
) (
  input  logic                lreq_valid,
  input  sbus_cmd_e           lreq_cmd,
  input  logic [ADDR_W-1:0]   lreq_addr,
  input  logic [NUM_TAGS-1:0] rd_hit_vec,
  input  logic [NUM_TAGS-1:0] other_hit_vec,
  input  logic                breq_valid,
  input  sbus_cmd_e           breq_cmd,
  input  logic [ADDR_W-1:0]   breq_addr,
  input  logic [TAG_W-1:0]    breq_tag,
  input  logic                free_any,
  input  logic [TAG_W-1:0]    free_tag,
  output logic                do_issue,
  output logic                do_join,
  output logic                do_block,
  output logic                do_nack,
  output logic [TAG_W-1:0]    join_tag,
  output logic [TAG_W-1:0]    out_tag
);

  logic             bus_same;
  logic             any_rd;
  logic             any_other;
  logic [TAG_W-1:0] tbl_rd_tag;

  assign bus_same = breq_valid && (breq_addr == lreq_addr);

  always_comb begin
    tbl_rd_tag = '0;
    for (int i = int'(NUM_TAGS) - 1; i >= 0; i--) begin
      if (rd_hit_vec[i]) tbl_rd_tag = TAG_W'(i);
    end
  end

  assign any_rd    = (|rd_hit_vec) || (bus_same && (breq_cmd == CMD_RD));
  assign any_other = (|other_hit_vec) || (bus_same && (breq_cmd != CMD_RD));
  assign join_tag  = (|rd_hit_vec) ? tbl_rd_tag : breq_tag;

  always_comb begin
    do_issue = 1'b0;
    do_join  = 1'b0;
    do_block = 1'b0;
    do_nack  = 1'b0;
    if (lreq_valid) begin
      if (lreq_cmd == CMD_RD) begin
        do_block = any_other;
        do_join  = !any_other && any_rd;
      end else begin
        do_block = any_other || any_rd;
      end
      if (!do_block && !do_join) begin
        do_issue = free_any;
        do_nack  = !free_any;
      end
    end
  end

  assign out_tag = do_issue ? free_tag : (do_join ? join_tag : '0);

endmodule

// File: rtl/sbus_txn_table.sv
module sbus_txn_table
  import sbus_tt_pkg::*;
#(
  parameter int unsigned TAG_W     = 7,
  parameter int unsigned ADDR_W    = 26,
  parameter int unsigned NODE_ID   = 0,
  parameter int unsigned LOCAL_MAX = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lreq_valid,
  input  logic [1:0]        lreq_cmd,
  input  logic [ADDR_W-1:0] lreq_addr,
  output logic              lreq_issue,
  output logic              lreq_snarf,
  output logic              lreq_block,
  output logic              lreq_nack,
  output logic [TAG_W-1:0]  lreq_tag,
  input  logic              breq_valid,
  input  logic [1:0]        breq_cmd,
  input  logic [ADDR_W-1:0] breq_addr,
  input  logic [TAG_W-1:0]  breq_tag,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic              rsp_last,
  output logic              rsp_err,
  output logic              rsp_snarf,
  output logic              rsp_local
);

  localparam int unsigned NUM_TAGS   = 1 << TAG_W;
  localparam int unsigned LOCAL_BASE = node_tag_base(NODE_ID, LOCAL_MAX);
  localparam int unsigned CNT_W      = $clog2(LOCAL_MAX + 1);

  sbus_cmd_e l_cmd;
  sbus_cmd_e b_cmd;
  assign l_cmd = sbus_cmd_e'(lreq_cmd);
  assign b_cmd = sbus_cmd_e'(breq_cmd);

  // Named internal events for the checker.
  logic [NUM_TAGS-1:0] valid_vec;
  logic [NUM_TAGS-1:0] expect_vec;
  logic [NUM_TAGS-1:0] joined_vec;
  logic [NUM_TAGS-1:0] rd_hit_vec;
  logic [NUM_TAGS-1:0] other_hit_vec;
  logic                table_hit;
  logic                free_any;
  logic [TAG_W-1:0]    free_tag;
  logic [CNT_W-1:0]    local_busy;
  logic [TAG_W-1:0]    join_tag;

  assign table_hit = (|rd_hit_vec) || (|other_hit_vec);

  sbus_tt_entries #(
    .TAG_W   (TAG_W),
    .ADDR_W  (ADDR_W),
    .NUM_TAGS(NUM_TAGS)
  ) u_entries (
    .clk          (clk),
    .rst_n        (rst_n),
    .l_alloc      (lreq_issue),
    .l_tag        (free_tag),
    .l_cmd        (l_cmd),
    .l_addr       (lreq_addr),
    .r_alloc      (breq_valid),
    .r_tag        (breq_tag),
    .r_cmd        (b_cmd),
    .r_addr       (breq_addr),
    .rsp_valid    (rsp_valid),
    .rsp_tag      (rsp_tag),
    .rsp_last     (rsp_last),
    .join_set     (lreq_snarf),
    .join_tag     (join_tag),
    .look_addr    (lreq_addr),
    .valid_vec    (valid_vec),
    .expect_vec   (expect_vec),
    .joined_vec   (joined_vec),
    .rd_hit_vec   (rd_hit_vec),
    .other_hit_vec(other_hit_vec)
  );

  sbus_tt_tag_pool #(
    .TAG_W     (TAG_W),
    .NUM_TAGS  (NUM_TAGS),
    .LOCAL_BASE(LOCAL_BASE),
    .LOCAL_MAX (LOCAL_MAX),
    .CNT_W     (CNT_W)
  ) u_pool (
    .valid_vec(valid_vec),
    .free_any (free_any),
    .free_tag (free_tag),
    .busy_cnt (local_busy)
  );

  sbus_tt_issue_ctl #(
    .TAG_W   (TAG_W),
    .ADDR_W  (ADDR_W),
    .NUM_TAGS(NUM_TAGS)
  ) u_ctl (
    .lreq_valid   (lreq_valid),
    .lreq_cmd     (l_cmd),
    .lreq_addr    (lreq_addr),
    .rd_hit_vec   (rd_hit_vec),
    .other_hit_vec(other_hit_vec),
    .breq_valid   (breq_valid),
    .breq_cmd     (b_cmd),
    .breq_addr    (breq_addr),
    .breq_tag     (breq_tag),
    .free_any     (free_any),
    .free_tag     (free_tag),
    .do_issue     (lreq_issue),
    .do_join      (lreq_snarf),
    .do_block     (lreq_block),
    .do_nack      (lreq_nack),
    .join_tag     (join_tag),
    .out_tag      (lreq_tag)
  );

  logic rsp_known;
  assign rsp_known = expect_vec[rsp_tag];
  assign rsp_err   = rsp_valid && !rsp_known;
  assign rsp_snarf = rsp_valid && rsp_known && joined_vec[rsp_tag];
  assign rsp_local = rsp_valid && rsp_known &&
                     tag_is_local(32'(rsp_tag), LOCAL_BASE, LOCAL_MAX);

endmodule

// File: rtl/sbus_txn_table_chk.sv
module sbus_txn_table_chk #(
  parameter int unsigned TAG_W     = 7,
  parameter int unsigned NUM_TAGS  = 128,
  parameter int unsigned LOCAL_MAX = 7,
  parameter int unsigned LOCAL_BASE = 0,
  parameter int unsigned CNT_W     = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lreq_valid,
  input logic [1:0]          lreq_cmd,
  input logic                lreq_issue,
  input logic                lreq_snarf,
  input logic                lreq_block,
  input logic                lreq_nack,
  input logic [TAG_W-1:0]    lreq_tag,
  input logic                breq_valid,
  input logic [TAG_W-1:0]    breq_tag,
  input logic                rsp_valid,
  input logic [TAG_W-1:0]    rsp_tag,
  input logic                rsp_last,
  input logic                rsp_err,
  input logic [NUM_TAGS-1:0] valid_vec,
  input logic [CNT_W-1:0]    local_busy,
  input logic                table_hit
);

  p_one_decision_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lreq_issue, lreq_snarf, lreq_block, lreq_nack}));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !lreq_valid |-> !(lreq_issue || lreq_snarf || lreq_block || lreq_nack));

  p_local_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    local_busy <= CNT_W'(LOCAL_MAX));

  p_nack_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_nack |-> (local_busy == CNT_W'(LOCAL_MAX)));

  p_issue_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_issue |-> (32'(lreq_tag) >= LOCAL_BASE) && (32'(lreq_tag) < LOCAL_BASE + LOCAL_MAX));

  p_issue_free_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_issue |-> !valid_vec[lreq_tag]);

  p_issue_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_issue |=> valid_vec[$past(lreq_tag)]);

  p_no_issue_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_issue |-> !table_hit);

  p_one_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lreq_issue && lreq_cmd[1]) |=> ##1 !valid_vec[$past(lreq_tag, 2)]);

  p_free_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_last && !rsp_err && !(breq_valid && (breq_tag == rsp_tag)))
      |=> !valid_vec[$past(rsp_tag)]);

  p_stray_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !valid_vec[rsp_tag]) |-> rsp_err);

endmodule

bind sbus_txn_table sbus_txn_table_chk #(
  .TAG_W     (TAG_W),
  .NUM_TAGS  (NUM_TAGS),
  .LOCAL_MAX (LOCAL_MAX),
  .LOCAL_BASE(LOCAL_BASE),
  .CNT_W     (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lreq_valid(lreq_valid),
  .lreq_cmd  (lreq_cmd),
  .lreq_issue(lreq_issue),
  .lreq_snarf(lreq_snarf),
  .lreq_block(lreq_block),
  .lreq_nack (lreq_nack),
  .lreq_tag  (lreq_tag),
  .breq_valid(breq_valid),
  .breq_tag  (breq_tag),
  .rsp_valid (rsp_valid),
  .rsp_tag   (rsp_tag),
  .rsp_last  (rsp_last),
  .rsp_err   (rsp_err),
  .valid_vec (valid_vec),
  .local_busy(local_busy),
  .table_hit (table_hit)
);

// File: tb/sbus_txn_table_tb.sv
`timescale 1ns/1ps
module sbus_txn_table_tb;

  localparam int TW   = 3;
  localparam int AW   = 6;
  localparam int NODE = 1;
  localparam int LMAX = 3;
  localparam int NT   = 1 << TW;
  localparam int BASE = NODE * LMAX;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lreq_valid = 1'b0;
  logic [1:0]    lreq_cmd = '0;
  logic [AW-1:0] lreq_addr = '0;
  logic          lreq_issue, lreq_snarf, lreq_block, lreq_nack;
  logic [TW-1:0] lreq_tag;
  logic          breq_valid = 1'b0;
  logic [1:0]    breq_cmd = '0;
  logic [AW-1:0] breq_addr = '0;
  logic [TW-1:0] breq_tag = '0;
  logic          rsp_valid = 1'b0;
  logic [TW-1:0] rsp_tag = '0;
  logic          rsp_last = 1'b0;
  logic          rsp_err, rsp_snarf, rsp_local;

  always #5 clk = ~clk;

  sbus_txn_table #(.TAG_W(TW), .ADDR_W(AW), .NODE_ID(NODE), .LOCAL_MAX(LMAX)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lreq_valid(lreq_valid), .lreq_cmd(lreq_cmd), .lreq_addr(lreq_addr),
    .lreq_issue(lreq_issue), .lreq_snarf(lreq_snarf), .lreq_block(lreq_block),
    .lreq_nack(lreq_nack), .lreq_tag(lreq_tag),
    .breq_valid(breq_valid), .breq_cmd(breq_cmd), .breq_addr(breq_addr), .breq_tag(breq_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_last(rsp_last),
    .rsp_err(rsp_err), .rsp_snarf(rsp_snarf), .rsp_local(rsp_local)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Bench model of the table contents.
  bit       m_v [NT];
  bit [1:0] m_c [NT];
  bit [AW-1:0] m_a [NT];
  bit       m_j [NT];

  task automatic check(string sc, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", sc, what, act, exp);
    end
  endtask

  task automatic cyc(string sc, bit lv, bit [1:0] lc, bit [AW-1:0] la,
                     bit bv, bit [1:0] bc, bit [AW-1:0] ba, bit [TW-1:0] bt,
                     bit rv, bit [TW-1:0] rt, bit rl);
    bit hit_rd, hit_oth, same, e_iss, e_join, e_blk, e_nack, has_free;
    int j_tag, f_tag, e_tag;
    bit e_err, e_js, e_loc, rsp_ok;
    @(negedge clk);
    lreq_valid = lv; lreq_cmd = lc; lreq_addr = la;
    breq_valid = bv; breq_cmd = bc; breq_addr = ba; breq_tag = bt;
    rsp_valid = rv; rsp_tag = rt; rsp_last = rl;
    #1;
    // expected decision
    hit_rd = 0; hit_oth = 0; j_tag = 0;
    for (int t = NT - 1; t >= 0; t--)
      if (m_v[t] && m_a[t] == la) begin
        if (m_c[t] == 2'b00) begin hit_rd = 1; j_tag = t; end
        else hit_oth = 1;
      end
    same = bv && (ba == la);
    if (same && bc != 2'b00) hit_oth = 1;
    if (same && bc == 2'b00 && !hit_rd) begin hit_rd = 1; j_tag = bt; end
    has_free = 0; f_tag = 0;
    for (int t = BASE + LMAX - 1; t >= BASE; t--)
      if (!m_v[t]) begin has_free = 1; f_tag = t; end
    e_iss = 0; e_join = 0; e_blk = 0; e_nack = 0;
    if (lv) begin
      if (lc == 2'b00) begin e_blk = hit_oth; e_join = !hit_oth && hit_rd; end
      else e_blk = hit_oth || hit_rd;
      if (!e_blk && !e_join) begin e_iss = has_free; e_nack = !has_free; end
    end
    e_tag = e_iss ? f_tag : (e_join ? j_tag : 0);
    check(sc, "issue", lreq_issue, e_iss);
    check(sc, "snarf", lreq_snarf, e_join);
    check(sc, "block", lreq_block, e_blk);
    check(sc, "nack",  lreq_nack,  e_nack);
    check(sc, "tag",   lreq_tag,   e_tag);
    rsp_ok = m_v[rt] && (m_c[rt][1] == 1'b0);
    e_err = rv && !rsp_ok;
    e_js  = rv && rsp_ok && m_j[rt];
    e_loc = rv && rsp_ok && (rt >= BASE) && (rt < BASE + LMAX);
    check(sc, "rsp_err",   rsp_err,   e_err);
    check(sc, "rsp_snarf", rsp_snarf, e_js);
    check(sc, "rsp_local", rsp_local, e_loc);
    @(posedge clk);
    // model update
    for (int t = 0; t < NT; t++)
      if (m_v[t] && m_c[t][1]) begin m_v[t] = 0; m_j[t] = 0; end
    if (rv && rl && rsp_ok) begin m_v[rt] = 0; m_j[rt] = 0; end
    if (e_iss) begin m_v[f_tag] = 1; m_c[f_tag] = lc; m_a[f_tag] = la; m_j[f_tag] = 0; end
    if (bv) begin m_v[bt] = 1; m_c[bt] = bc; m_a[bt] = ba; m_j[bt] = 0; end
    if (e_join) m_j[j_tag] = 1;
  endtask

  task automatic idle(string sc);
    cyc(sc, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain(string sc);
    for (int t = 0; t < NT; t++)
      if (m_v[t] && !m_c[t][1]) cyc(sc, 0, 0, 0, 0, 0, 0, 0, 1, t[TW-1:0], 1);
    idle(sc);
    idle(sc);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin m_v[t] = 0; m_c[t] = 0; m_a[t] = 0; m_j[t] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state, R12 idle outputs quiet
    idle("R1 R12 after reset");
    cyc("R1 first issue", 1, 2'b00, 6'd5, 0, 0, 0, 0, 0, 0, 0);
    drain("R1 drain");

    // R2 lowest free tag, R3 NACK when full, R7 beats, R9 order
    cyc("R2 fill", 1, 2'b01, 6'd10, 0, 0, 0, 0, 0, 0, 0);
    cyc("R2 fill", 1, 2'b01, 6'd11, 0, 0, 0, 0, 0, 0, 0);
    cyc("R2 fill", 1, 2'b01, 6'd12, 0, 0, 0, 0, 0, 0, 0);
    cyc("R3 full nack", 1, 2'b00, 6'd13, 0, 0, 0, 0, 0, 0, 0);
    cyc("R7 mid beat keeps", 1, 2'b00, 6'd13, 0, 0, 0, 0, 1, 3'd4, 0);
    cyc("R7 last beat same cycle", 1, 2'b00, 6'd13, 0, 0, 0, 0, 1, 3'd4, 1);
    cyc("R7 R2 reuse freed tag", 1, 2'b00, 6'd13, 0, 0, 0, 0, 0, 0, 0);
    cyc("R9 out of order", 0, 0, 0, 0, 0, 0, 0, 1, 3'd5, 1);
    cyc("R9 out of order", 0, 0, 0, 0, 0, 0, 0, 1, 3'd3, 1);
    cyc("R9 R10 repeat freed tag", 0, 0, 0, 0, 0, 0, 0, 1, 3'd3, 1);
    drain("R9 drain");

    // R4 R5 R6 sweep over remote/local command pairs
    for (int rc = 0; rc < 4; rc++)
      for (int lc = 0; lc < 4; lc++) begin
        cyc("R4 R5 R6 sweep remote", 0, 0, 0, 1, rc[1:0], 6'd20, 3'd0, 0, 0, 0);
        cyc("R4 R5 R6 sweep local", 1, lc[1:0], 6'd20, 0, 0, 0, 0, 0, 0, 0);
        cyc("R4 R5 R6 sweep other line", 1, lc[1:0], 6'd21, 0, 0, 0, 0, 0, 0, 0);
        drain("R5 sweep drain");
        cyc("R4 R5 R6 sweep same cycle", 1, lc[1:0], 6'd22, 1, rc[1:0], 6'd22, 3'd6, 0, 0, 0);
        drain("R5 sweep drain");
      end

    // R5 two reads in flight: lowest table tag joined
    cyc("R5 setup", 0, 0, 0, 1, 2'b00, 6'd25, 3'd7, 0, 0, 0);
    cyc("R5 setup", 0, 0, 0, 1, 2'b00, 6'd25, 3'd1, 0, 0, 0);
    cyc("R5 join lowest", 1, 2'b00, 6'd25, 1, 2'b00, 6'd25, 3'd0, 0, 0, 0);
    drain("R5 drain");

    // R10 stray and no-response tags, R8 one-shot lifetime
    cyc("R10 free tag", 0, 0, 0, 0, 0, 0, 0, 1, 3'd6, 1);
    cyc("R10 wb setup", 0, 0, 0, 1, 2'b10, 6'd30, 3'd1, 0, 0, 0);
    cyc("R10 R8 wb no response", 1, 2'b01, 6'd30, 0, 0, 0, 0, 1, 3'd1, 1);
    cyc("R8 wb gone", 1, 2'b01, 6'd30, 0, 0, 0, 0, 0, 0, 0);
    drain("R8 drain");
    cyc("R8 local inv", 1, 2'b11, 6'd31, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8 R6 inv blocks load", 1, 2'b00, 6'd31, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8 inv freed", 1, 2'b00, 6'd31, 0, 0, 0, 0, 0, 0, 0);
    drain("R8 drain");

    // R11 local vs remote responses
    cyc("R11 remote rd", 1, 2'b00, 6'd41, 1, 2'b00, 6'd40, 3'd2, 0, 0, 0);
    cyc("R11 remote response", 0, 0, 0, 0, 0, 0, 0, 1, 3'd2, 1);
    cyc("R11 local response", 0, 0, 0, 0, 0, 0, 0, 1, 3'd3, 1);
    drain("R11 drain");
    idle("R12 final idle");

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule